// File: doc/BRIEF.md
# Weight and Status Register Block with Sticky and Boot-Locked Fields

This block is a 32-bit control/status register file behind a plain synchronous bus port. Each cycle it takes an address, a write strobe and write data. One cycle later it returns registered read data. It holds one arbitration-weight register made of four 5-bit lanes, and a small status register that reports the boot lock. Downstream arbitration logic reads the four lanes directly from a flat output port.

Each lane carries its own access policy and reset behaviour, and the hardware enforces them. There are two reset inputs. The hard (power-on) reset is asynchronous and active low, and it returns every lane to its power-on value. The soft reset is synchronous and active high. It reloads the power-on value only into lanes that are not sticky; sticky lanes keep what they hold. A boot-locked lane can be written like an ordinary read/write lane until the boot-complete input has been seen high. From then on it is read-only, whether or not anyone wrote it before. The lock is one-way, and only the hard reset clears it.

The weight register is at address 0 and the status register is at address 1. The lane at bits [12:8] is boot-locked. The lane at bits [28:24] is read/write and sticky. The other two lanes are plain read/write.

Top module: `regblk_lockstick`

## Requirements
- R1: While hard_rst_n is low, every lane reads 1 on weight_o, rd_data is 0 and the boot lock is clear, even if soft_rst is also high. This holds whatever value any lane held before the reset, sticky lanes included.
- R2: A write to address 0 with soft_rst low loads the lanes at [4:0], [20:16] and [28:24] from the matching write-data bits, visible on weight_o after that clock edge.
- R3: Read data bits [7:5], [15:13], [23:21] and [31:29] are always 0, and writing ones to those bits has no effect on any lane.
- R4: In a cycle with soft_rst high, lanes [4:0], [12:8] and [20:16] load the value 1.
- R5: Lane [28:24] keeps its value through a soft reset, and a write in the same cycle as the soft reset does not change it.
- R6: Lane [12:8] takes write data like the other read/write lanes while boot_done has never been high since the hard reset.
- R7: Once boot_done has been high in any cycle, including the cycle of the write itself, writes leave lane [12:8] unchanged, whether or not it was written before boot.
- R8: The boot lock reads as bit 0 of the status register at address 1, with all other status bits 0. It stays set through soft resets and through boot_done falling, and only the hard reset clears it.
- R9: rd_data after a clock edge holds the register selected by addr in the cycle before that edge, with the field values from before any write at that same edge. Addresses other than 0 and 1 read as 0.
- R10: In a cycle with soft_rst high, a write to address 0 is ignored by every lane. The non-sticky lanes take 1 and the sticky lane keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous active-high soft reset |
| boot_done | input | 1 | Boot complete; sets the one-way lock |
| addr | input | 4 | Register address (0 weights, 1 status) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, one cycle after addr |
| weight_o | output | 20 | The four lanes, lane 0 in the low five bits |

## Verification
Suppose the lock flop is wrong. It then shows up at the next edge as a status read of 1 where 0 is expected, or as the boot-locked lane taking or refusing a write against the expected value. Each lane drives weight_o straight from its flop, so a faulty reset class or stickiness choice appears on the port one edge after the soft or hard reset. A wrong read path appears on rd_data one cycle after the address is presented. The sweep writes every 5-bit value into every lane both before and after boot, and each lane is mixed with a different offset. A lane swap, a stuck bit or a leak from the reserved bits therefore changes a compared value.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

  localparam int REG_W    = 32;
  localparam int FIELD_W  = 5;
  localparam int LANES    = 4;
  localparam int STRIDE   = 8;
  localparam int FLAT_W   = LANES * FIELD_W;

  typedef enum logic [1:0] {
    SEL_WEIGHT = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_NONE   = 2'd2
  } rd_sel_e;

  // take one lane out of a bus word
  function automatic logic [FIELD_W-1:0] lane_of(input logic [REG_W-1:0] word,
                                                 input int idx);
    lane_of = word[idx*STRIDE +: FIELD_W];
  endfunction

  // take one lane out of the flat field vector
  function automatic logic [FIELD_W-1:0] flat_lane(input logic [FLAT_W-1:0] flat,
                                                   input int idx);
    flat_lane = flat[idx*FIELD_W +: FIELD_W];
  endfunction

  // place the lanes in their bus positions, spare bits zero
  function automatic logic [REG_W-1:0] pack_lanes(input logic [FLAT_W-1:0] flat);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < LANES; i++) begin
      w[i*STRIDE +: FIELD_W] = flat[i*FIELD_W +: FIELD_W];
    end
    return w;
  endfunction

  // bits that no lane occupies
  function automatic logic [REG_W-1:0] spare_mask();
    logic [REG_W-1:0] m;
    m = '1;
    for (int i = 0; i < LANES; i++) begin
      m[i*STRIDE +: FIELD_W] = '0;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic locked);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = locked;
    return w;
  endfunction

endpackage

// File: rtl/regblk_field.sv
module regblk_field #(
  parameter int          W        = 5,
  parameter logic [W-1:0] RST_VAL = 1,
  parameter bit          STICKY   = 1'b0,
  parameter bit          BOOTLOCK = 1'b0
) (
  input  logic         clk,
  input  logic         hard_rst_n,
  input  logic         soft_rst,
  input  logic         wr_hit,
  input  logic         lock_now,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic write_open;
  logic take;
  logic soft_load;

  generate
    if (BOOTLOCK) begin : g_lock
      assign write_open = !lock_now;
    end else begin : g_free
      assign write_open = 1'b1;
    end
    if (STICKY) begin : g_sticky
      assign soft_load = 1'b0;
    end else begin : g_plain
      assign soft_load = soft_rst;
    end
  endgenerate

  assign take = wr_hit && write_open && !soft_rst;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      q <= RST_VAL;
    end else if (soft_load) begin
      q <= RST_VAL;
    end else if (take) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/regblk_lock.sv
module regblk_lock (
  input  logic clk,
  input  logic hard_rst_n,
  input  logic boot_done,
  output logic lock_q,
  output logic lock_now
);

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      lock_q <= 1'b0;
    end else if (boot_done) begin
      lock_q <= 1'b1;
    end
  end

  assign lock_now = lock_q || boot_done;

endmodule

// File: rtl/regblk_rdpath.sv
module regblk_rdpath
  import regblk_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int WEIGHT_ADDR = 0,
  parameter int STATUS_ADDR = 1
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FLAT_W-1:0] flat,
  input  logic              lock_q,
  output logic [REG_W-1:0]  rd_data
);

  rd_sel_e         sel;
  logic [REG_W-1:0] rd_next;

  always_comb begin
    if (addr == ADDR_W'(WEIGHT_ADDR))      sel = SEL_WEIGHT;
    else if (addr == ADDR_W'(STATUS_ADDR)) sel = SEL_STATUS;
    else                                   sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_WEIGHT: rd_next = pack_lanes(flat);
      SEL_STATUS: rd_next = status_word(lock_q);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) rd_data <= '0;
    else             rd_data <= rd_next;
  end

endmodule

// File: rtl/regblk_lockstick.sv
module regblk_lockstick
  import regblk_pkg::*;
#(
  parameter int             ADDR_W      = 4,
  parameter int             WEIGHT_ADDR = 0,
  parameter int             STATUS_ADDR = 1,
  parameter logic [LANES-1:0] STICKY_MASK = 4'b1000,
  parameter logic [LANES-1:0] LOCK_MASK   = 4'b0010,
  parameter logic [FIELD_W-1:0] RESET_VAL = 5'd1
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic              boot_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [FLAT_W-1:0] weight_o
);

  logic wr_hit;
  logic lock_q;
  logic lock_now;

  assign wr_hit = wr_en && (addr == ADDR_W'(WEIGHT_ADDR));

  regblk_lock u_lock (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .boot_done  (boot_done),
    .lock_q     (lock_q),
    .lock_now   (lock_now)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [FIELD_W-1:0] lane_q;
    regblk_field #(
      .W        (FIELD_W),
      .RST_VAL  (RESET_VAL),
      .STICKY   (STICKY_MASK[i]),
      .BOOTLOCK (LOCK_MASK[i])
    ) u_field (
      .clk        (clk),
      .hard_rst_n (hard_rst_n),
      .soft_rst   (soft_rst),
      .wr_hit     (wr_hit),
      .lock_now   (lock_now),
      .wdata      (lane_of(wr_data, i)),
      .q          (lane_q)
    );
    assign weight_o[i*FIELD_W +: FIELD_W] = lane_q;
  end

  regblk_rdpath #(
    .ADDR_W      (ADDR_W),
    .WEIGHT_ADDR (WEIGHT_ADDR),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_rd (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .addr       (addr),
    .flat       (weight_o),
    .lock_q     (lock_q),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/regblk_chk.sv
module regblk_chk
  import regblk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              hard_rst_n,
  input logic              soft_rst,
  input logic              boot_done,
  input logic              lock_q,
  input logic              wr_hit,
  input logic [REG_W-1:0]  wr_data,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  rd_data,
  input logic [FLAT_W-1:0] weight_o
);

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (rd_data & spare_mask()) == '0); // R3

  AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (wr_hit && !soft_rst) |=> flat_lane(weight_o, 0) == $past(lane_of(wr_data, 0))); // R2

  AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (!hard_rst_n)
    soft_rst |=> (flat_lane(weight_o, 0) == 5'd1 && flat_lane(weight_o, 1) == 5'd1
                  && flat_lane(weight_o, 2) == 5'd1)); // R4

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!hard_rst_n)
    soft_rst |=> $stable(flat_lane(weight_o, 3))); // R5

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ((lock_q || boot_done) && !soft_rst) |=> $stable(flat_lane(weight_o, 1))); // R7

  AST_LOCK_ONEWAY: assert property (@(posedge clk) disable iff (!hard_rst_n)
    lock_q |=> lock_q); // R8

  AST_READ_LAG: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (addr == ADDR_W'(0)) |=> rd_data == $past(pack_lanes(weight_o))); // R9

endmodule

bind regblk_lockstick regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .hard_rst_n (hard_rst_n),
  .soft_rst   (soft_rst),
  .boot_done  (boot_done),
  .lock_q     (lock_q),
  .wr_hit     (wr_hit),
  .wr_data    (wr_data),
  .addr       (addr),
  .rd_data    (rd_data),
  .weight_o   (weight_o)
);

// File: tb/sim_regblk_lockstick.sv
`timescale 1ns/1ps
module sim_regblk_lockstick;

  logic        clk = 1'b0;
  logic        hard_rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        boot_done = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [19:0] weight_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] m_lane [4];
  logic       m_lock;

  always #2 clk = ~clk;

  regblk_lockstick u0 (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst),
    .boot_done(boot_done), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .weight_o(weight_o)
  );

  function automatic logic [19:0] m_flat();
    logic [19:0] f = '0;
    for (int i = 0; i < 4; i++) f = f | (20'(m_lane[i]) << (5 * i));
    return f;
  endfunction

  function automatic logic [31:0] m_word(input logic [3:0] a);
    logic [31:0] w = '0;
    if (a == 4'd0) begin
      for (int i = 0; i < 4; i++) w = w + (32'(m_lane[i]) << (8 * i));
    end else if (a == 4'd1) begin
      w = {31'd0, m_lock};
    end
    return w;
  endfunction

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_hard();
    for (int i = 0; i < 4; i++) m_lane[i] = 5'd1;
    m_lock = 1'b0;
  endtask

  // one bus cycle, then check both outputs
  task automatic step(input string tag, input logic [3:0] a, input logic we,
                      input logic [31:0] wd, input logic sr, input logic bd);
    logic [31:0] exp_rd;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = wd; soft_rst = sr; boot_done = bd;
    exp_rd = m_word(a);
    @(posedge clk);
    if (sr) begin
      for (int i = 0; i < 3; i++) m_lane[i] = 5'd1;
    end else if (we && a == 4'd0) begin
      for (int i = 0; i < 4; i++)
        if (!(i == 1 && (m_lock || bd))) m_lane[i] = wd[8*i +: 5];
    end
    if (bd) m_lock = 1'b1;
    #1;
    check32(tag, "rd_data", rd_data, exp_rd);
    check32(tag, "weight_o", {12'd0, weight_o}, {12'd0, m_flat()});
  endtask

  task automatic hard_reset(input logic with_soft);
    @(negedge clk);
    hard_rst_n = 1'b0; soft_rst = with_soft; wr_en = 1'b0; boot_done = 1'b0;
    model_hard();
    #1;
    check32("R1", "weight_o in reset", {12'd0, weight_o}, {12'd0, m_flat()});
    check32("R1", "rd_data in reset", rd_data, 32'd0);
    @(negedge clk);
    @(negedge clk);
    hard_rst_n = 1'b1; soft_rst = 1'b0;
  endtask

  function automatic logic [31:0] mix(input int v);
    logic [31:0] w = 32'hFFFF_FFFF;
    for (int i = 0; i < 4; i++) w[8*i +: 5] = 5'((v + 7 * i) % 32);
    return w;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_hard();
    hard_reset(1'b0);
    step("R9", 4'd1, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R8", 4'd1, 1'b0, 32'd0, 1'b0, 1'b0);

    // pre-boot sweep: every value into every lane, spare bits set (R2 R3 R6)
    for (int v = 0; v < 32; v++) begin
      step("R2", 4'd0, 1'b1, mix(v), 1'b0, 1'b0);
      step("R6", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);
    end
    step("R3", 4'd0, 1'b1, 32'hE0E0_E0E0 | mix(9), 1'b0, 1'b0);
    step("R3", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R9", 4'd7, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R9", 4'd15, 1'b1, mix(3), 1'b0, 1'b0);

    // soft reset: non-sticky reload, sticky kept, write ignored
    step("R4", 4'd0, 1'b0, 32'd0, 1'b1, 1'b0);
    step("R5", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R2", 4'd0, 1'b1, mix(20), 1'b0, 1'b0);
    step("R10", 4'd0, 1'b1, mix(5), 1'b1, 1'b0);
    step("R5", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);

    // boot: same-cycle write is blocked for the locked lane
    step("R7", 4'd0, 1'b1, mix(11), 1'b0, 1'b1);
    step("R8", 4'd1, 1'b0, 32'd0, 1'b0, 1'b0);
    for (int v = 0; v < 32; v++) begin
      step("R7", 4'd0, 1'b1, mix(v + 3), 1'b0, 1'b0);
      step("R7", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);
    end
    step("R8", 4'd1, 1'b0, 32'd0, 1'b1, 1'b0);
    step("R8", 4'd1, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R7", 4'd0, 1'b1, mix(17), 1'b0, 1'b0);
    step("R7", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);

    // hard reset with soft reset held: sticky lane returns to 1
    hard_reset(1'b1);
    step("R1", 4'd1, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R1", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);

    // lock with no earlier write, boot_done pulsed
    step("R7", 4'd0, 1'b0, 32'd0, 1'b0, 1'b1);
    step("R7", 4'd0, 1'b1, mix(30), 1'b0, 1'b0);
    step("R7", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R8", 4'd1, 1'b0, 32'd0, 1'b0, 1'b0);
    hard_reset(1'b0);
    step("R6", 4'd0, 1'b1, mix(22), 1'b0, 1'b0);
    step("R6", 4'd0, 1'b0, 32'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule